// File: doc/BRIEF.md
# Serial-bus arbiter command channel

This block is one command channel of a power-management serial-bus arbiter. Software stages up to eight payload bytes in two 32-bit write-data registers, then writes a command word carrying an opcode, an 8-bit register address and a byte count stored as length minus one. Writing the command word starts the transfer. The channel then moves the bytes one at a time over a byte-wide request port to the addressed peripheral register and its successors.

Each byte occupies the request port for a fixed number of cycles, set by a parameter. The peripheral may refuse any byte. When the transfer ends, the channel raises a done flag in its status register, together with any error flags. Software polls that register for completion. For reads, the returned bytes are packed into two read-data registers.

Opcodes other than the two long extended-register transfers finish at once as failures. A write-protect bit in the configuration register turns long writes away as denied. A command written while a transfer is running is discarded, and the discard is reported when the running transfer finishes.

Top module: `cmd_channel_engine`

## Requirements
- R1: After reset, status, write-data, read-data and configuration registers all read zero and no peripheral request is active.
- R2: Register offsets are: command 0x00, configuration 0x04, status 0x08, write data 0x10 (bytes 0-3) and 0x14 (bytes 4-7), read data 0x18 (bytes 0-3) and 0x1C (bytes 4-7). The command word holds the opcode in bits 31:27, the register address in bits 11:4 and the byte count minus one in bits 2:0. Reading offset 0x00 returns the last accepted command word.
- R3: Opcode 0 (long extended write) sends n = count+1 bytes, one after another. Byte k goes to register address+k. It is taken from data word k/4 at lane k%4, with the lowest byte in bits 7:0.
- R4: Opcode 1 (long extended read) fetches n bytes from register address+k and places byte k in read word k/4 at lane k%4. Lanes at or beyond n read zero.
- R5: Each byte holds the request for BYTE_LAT cycles. For a transfer that runs to the end, done appears exactly n*BYTE_LAT clock edges after the edge that accepts the command, and status reads zero until then.
- R6: Status bit 0 is done, bit 1 failure, bit 2 denied and bit 3 dropped. An accepted command clears all four bits. Done then stays set until the next accepted command, and no error bit is ever set without done.
- R7: If the peripheral refuses a byte (nack), the transfer stops after that byte and status becomes done|failure (0x3). Bytes accepted before the refusal stay written or captured.
- R8: Any opcode other than 0 and 1 completes on the accepting edge with status 0x3 and makes no peripheral request.
- R9: With configuration bit 0 set, opcode 0 completes on the accepting edge with status done|denied (0x5) and no peripheral request. Reads are not affected by this bit.
- R10: A command write during a running transfer is ignored: the command readback and the transfer are unchanged. Dropped (bit 3) is set together with done when the running transfer finishes.
- R11: During each byte, address, direction and write byte stay stable. The commit strobe is high on that byte's last request cycle, and the next byte's address is one higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| per_req | output | 1 | Byte request to the peripheral is active |
| per_we | output | 1 | 1 = write byte, 0 = read byte |
| per_addr | output | 8 | Peripheral register address of the current byte |
| per_wbyte | output | 8 | Byte to write |
| per_commit | output | 1 | Last cycle of the current byte; write/read takes effect |
| per_rbyte | input | 8 | Byte returned by the peripheral |
| per_nack | input | 1 | Peripheral refuses the current byte |

## Verification
The hardest state to reach from the ports is a second command arriving in the middle of a transfer. The bench has to write the command register again on the cycle right after acceptance and still predict when done appears. The run task therefore issues that extra write inline, and subtracts its cycle from the latency wait before checking for status 0x9. A second corner is a peripheral refusal partway through a transfer, which leaves a partly filled read word or a partly written register range. The stimulus reaches it by biasing random addresses toward the refusing top window of the register space, so transfers cross into it at every byte position.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned DW     = 32;

  localparam logic [BUS_AW-1:0] OFS_CMD  = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_CFG  = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_WD0  = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_WD1  = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_RD0  = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_RD1  = 8'h1C;

  localparam logic [4:0] OP_LONG_WR = 5'd0;
  localparam logic [4:0] OP_LONG_RD = 5'd1;

  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_FAIL = 1;
  localparam int unsigned ST_DENY = 2;
  localparam int unsigned ST_DROP = 3;

  typedef struct packed {
    logic [4:0]  op;
    logic [14:0] rsv_hi;
    logic [7:0]  reg_addr;
    logic        rsv_lo;
    logic [2:0]  cnt_m1;
  } cmd_t;
endpackage

// File: rtl/cce_regfile.sv
module cce_regfile
  import cce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     cmd_rb,
  input  logic [3:0]        status,
  input  logic [2*DW-1:0]   rd_bytes,
  output logic [2*DW-1:0]   wr_bytes,
  output logic              wr_protect,
  output logic              cmd_wr
);
  logic [DW-1:0] wd0_q, wd1_q;
  logic          wp_q;
  logic          wd0_en, wd1_en, cfg_en;

  assign wd0_en = bus_wr_en && (bus_addr == OFS_WD0);
  assign wd1_en = bus_wr_en && (bus_addr == OFS_WD1);
  assign cfg_en = bus_wr_en && (bus_addr == OFS_CFG);
  assign cmd_wr = bus_wr_en && (bus_addr == OFS_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd0_q <= '0;
      wd1_q <= '0;
      wp_q  <= 1'b0;
    end else begin
      if (wd0_en) wd0_q <= bus_wdata;
      if (wd1_en) wd1_q <= bus_wdata;
      if (cfg_en) wp_q  <= bus_wdata[0];
    end
  end

  assign wr_bytes   = {wd1_q, wd0_q};
  assign wr_protect = wp_q;

  always_comb begin
    unique case (bus_addr)
      OFS_CMD:  bus_rdata = cmd_rb;
      OFS_CFG:  bus_rdata = {{(DW-1){1'b0}}, wp_q};
      OFS_STAT: bus_rdata = {{(DW-4){1'b0}}, status};
      OFS_WD0:  bus_rdata = wd0_q;
      OFS_WD1:  bus_rdata = wd1_q;
      OFS_RD0:  bus_rdata = rd_bytes[DW-1:0];
      OFS_RD1:  bus_rdata = rd_bytes[2*DW-1:DW];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cce_sequencer.sv
module cce_sequencer
  import cce_pkg::*;
#(
  parameter int unsigned BYTE_LAT = 3
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [DW-1:0]   cmd_word,
  input  logic            wr_protect,
  input  logic [2*DW-1:0] wr_bytes,
  input  logic            per_nack,
  output logic            per_req,
  output logic            per_we,
  output logic [7:0]      per_addr,
  output logic [7:0]      per_wbyte,
  output logic            per_commit,
  output logic [3:0]      status,
  output logic [DW-1:0]   cmd_rb,
  output logic            cap_en,
  output logic            cap_clr,
  output logic [2:0]      cap_idx
);
  localparam int unsigned LW = (BYTE_LAT > 1) ? $clog2(BYTE_LAT) : 1;
  localparam logic [LW-1:0] LAT_LAST = LW'(BYTE_LAT - 1);

  cmd_t        cmd_q, cmd_d, nc;
  logic        busy_q, busy_d;
  logic        drop_q, drop_d;
  logic [2:0]  idx_q, idx_d;
  logic [LW-1:0] lat_q, lat_d;
  logic [3:0]  st_q, st_d;
  logic        accept, last_cyc, last_byte, is_rd, upd_en;

  assign nc        = cmd_t'(cmd_word);
  assign accept    = cmd_wr && !busy_q;
  assign last_cyc  = busy_q && (lat_q == LAT_LAST);
  assign last_byte = (idx_q == cmd_q.cnt_m1);
  assign is_rd     = (cmd_q.op == OP_LONG_RD);
  assign upd_en    = cmd_wr || busy_q;

  always_comb begin
    cmd_d  = cmd_q;
    busy_d = busy_q;
    drop_d = drop_q;
    idx_d  = idx_q;
    lat_d  = lat_q;
    st_d   = st_q;
    if (accept) begin
      cmd_d  = nc;
      st_d   = '0;
      drop_d = 1'b0;
      idx_d  = '0;
      lat_d  = '0;
      if (nc.op == OP_LONG_WR && wr_protect) begin
        st_d[ST_DONE] = 1'b1;
        st_d[ST_DENY] = 1'b1;
      end else if (nc.op == OP_LONG_WR || nc.op == OP_LONG_RD) begin
        busy_d = 1'b1;
      end else begin
        st_d[ST_DONE] = 1'b1;
        st_d[ST_FAIL] = 1'b1;
      end
    end else if (busy_q) begin
      if (cmd_wr) drop_d = 1'b1;
      if (last_cyc) begin
        lat_d = '0;
        if (per_nack || last_byte) begin
          busy_d        = 1'b0;
          st_d[ST_DONE] = 1'b1;
          st_d[ST_FAIL] = per_nack;
          st_d[ST_DROP] = drop_q || cmd_wr;
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end else begin
        lat_d = lat_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      idx_q  <= '0;
      lat_q  <= '0;
      st_q   <= '0;
    end else if (upd_en) begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
      drop_q <= drop_d;
      idx_q  <= idx_d;
      lat_q  <= lat_d;
      st_q   <= st_d;
    end
  end

  assign per_req    = busy_q;
  assign per_we     = busy_q && !is_rd;
  assign per_addr   = cmd_q.reg_addr + {5'b0, idx_q};
  assign per_wbyte  = wr_bytes[{idx_q, 3'b000} +: 8];
  assign per_commit = last_cyc;
  assign status     = st_q;
  assign cmd_rb     = cmd_q;
  assign cap_en     = last_cyc && is_rd && !per_nack;
  assign cap_idx    = idx_q;
  assign cap_clr    = accept && (nc.op == OP_LONG_RD);
endmodule

// File: rtl/cce_rdpack.sv
module cce_rdpack
  import cce_pkg::*;
#(
  parameter int unsigned LANES = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_clr,
  input  logic               cap_en,
  input  logic [2:0]         cap_idx,
  input  logic [7:0]         cap_byte,
  output logic [8*LANES-1:0] rd_bytes
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_en;
    assign lane_en = cap_clr || (cap_en && (cap_idx == 3'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= cap_clr ? 8'h00 : cap_byte;
    end
    assign rd_bytes[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/cmd_channel_engine.sv
module cmd_channel_engine
  import cce_pkg::*;
#(
  parameter int unsigned BYTE_LAT = 3
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        per_req,
  output logic        per_we,
  output logic [7:0]  per_addr,
  output logic [7:0]  per_wbyte,
  output logic        per_commit,
  input  logic [7:0]  per_rbyte,
  input  logic        per_nack
);
  logic [1:0]      rs_q;
  logic            rst_ns;
  logic [DW-1:0]   cmd_rb;
  logic [3:0]      st_w;
  logic [2*DW-1:0] rd_bytes, wr_bytes;
  logic            wr_protect, cmd_wr;
  logic            cap_en, cap_clr;
  logic [2:0]      cap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  cce_regfile u_regs (
    .clk(clk), .rst_n(rst_ns),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmd_rb(cmd_rb), .status(st_w),
    .rd_bytes(rd_bytes), .wr_bytes(wr_bytes),
    .wr_protect(wr_protect), .cmd_wr(cmd_wr)
  );

  cce_sequencer #(.BYTE_LAT(BYTE_LAT)) u_seq (
    .clk(clk), .rst_n(rst_ns),
    .cmd_wr(cmd_wr), .cmd_word(bus_wdata), .wr_protect(wr_protect),
    .wr_bytes(wr_bytes), .per_nack(per_nack),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr),
    .per_wbyte(per_wbyte), .per_commit(per_commit),
    .status(st_w), .cmd_rb(cmd_rb),
    .cap_en(cap_en), .cap_clr(cap_clr), .cap_idx(cap_idx)
  );

  cce_rdpack #(.LANES(8)) u_rdp (
    .clk(clk), .rst_n(rst_ns),
    .cap_clr(cap_clr), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_byte(per_rbyte), .rd_bytes(rd_bytes)
  );
endmodule

// File: rtl/cce_checker.sv
module cce_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       per_req,
  input logic       per_we,
  input logic [7:0] per_addr,
  input logic [7:0] per_wbyte,
  input logic       per_commit,
  input logic [3:0] status,
  input logic [4:0] cmd_op,
  input logic       cmd_wr
);
  // R11: byte held stable until its commit cycle
  a_r11_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && !per_commit) |=> (per_req && $stable(per_addr) && $stable(per_we) && $stable(per_wbyte)));

  // R11: next byte addresses the following register
  a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && per_commit) |=> (!per_req || per_addr == $past(per_addr) + 8'd1));

  // R6: done only when idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !per_req);

  // R6: done holds until a new command write
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !cmd_wr) |=> status[0]);

  // R6: no error flag without done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|status[3:1]) |-> status[0]);

  // R8: peripheral access only for the two implemented opcodes
  a_r8_access_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> (cmd_op == 5'd0 || cmd_op == 5'd1));

  // R5: done rises only after a commit or an immediate completion
  a_r5_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> ($past(per_commit) || $past(cmd_wr)));
endmodule

bind cmd_channel_engine cce_checker u_chk (
  .clk(clk), .rst_n(rst_ns),
  .per_req(per_req), .per_we(per_we), .per_addr(per_addr),
  .per_wbyte(per_wbyte), .per_commit(per_commit),
  .status(st_w), .cmd_op(cmd_rb[31:27]), .cmd_wr(cmd_wr)
);

// File: tb/cmd_channel_engine_tb.sv
module cmd_channel_engine_tb_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        per_req, per_we, per_commit, per_nack;
  logic [7:0]  per_addr, per_wbyte, per_rbyte;

  logic [7:0] pmem    [256];
  logic [7:0] exp_mem [256];
  int req_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmd_channel_engine #(.BYTE_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr),
    .per_wbyte(per_wbyte), .per_commit(per_commit),
    .per_rbyte(per_rbyte), .per_nack(per_nack)
  );

  // peripheral register model: top window 0xF8..0xFF refuses
  assign per_rbyte = pmem[per_addr];
  assign per_nack  = per_req && (per_addr >= 8'hF8);

  always @(posedge clk) begin
    if (per_req) req_cnt <= req_cnt + 1;
    if (per_req && per_commit && per_we && !per_nack) pmem[per_addr] <= per_wbyte;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic run(input logic [4:0] op, input logic [7:0] addr, input logic [2:0] cnt,
                     input logic [31:0] w0, input logic [31:0] w1, input bit wp, input bit drop);
    logic [31:0] cmd, rd;
    logic [63:0] wb, exp_rd;
    int n, att, ok, base, el;
    bit impl, denied, nack;
    logic [31:0] exp_st;
    string tag;
    bus_write(8'h04, {31'b0, wp});
    bus_write(8'h10, w0);
    bus_write(8'h14, w1);
    wb = {w1, w0};
    n = int'(cnt) + 1;
    cmd = {op, 15'b0, addr, 1'b0, cnt};
    impl = (op == 5'd0) || (op == 5'd1);
    denied = (op == 5'd0) && wp;
    att = 0; ok = 0; nack = 0;
    if (!impl) begin exp_st = 32'h3; tag = "R8"; end
    else if (denied) begin exp_st = 32'h5; tag = "R9"; end
    else begin
      for (int k = 0; k < n; k++) begin
        att++;
        if (((int'(addr) + k) & 255) >= 248) begin nack = 1; break; end
      end
      ok = nack ? att - 1 : att;
      exp_st = nack ? 32'h3 : 32'h1;
      tag = nack ? "R7" : (op == 5'd0 ? "R3" : "R4");
    end
    base = req_cnt;
    bus_write(8'h00, cmd);
    el = 0;
    if (att > 0) begin
      if (drop) begin
        bus_wr_en = 1'b1; bus_addr = 8'h00; bus_wdata = ~cmd;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
        el = 1;
        exp_st = exp_st | 32'h8;
        tag = "R10";
      end else begin
        bus_read(8'h08, rd);
        check("R6 status cleared on accept", rd, 32'h0);
      end
      repeat (att * LAT - 1 - el) @(posedge clk);
      @(negedge clk);
      bus_read(8'h08, rd);
      check("R5 not done one cycle early", rd, 32'h0);
      @(posedge clk);
      @(negedge clk);
    end
    bus_read(8'h08, rd);
    check({tag, " status"}, rd, exp_st);
    check({tag, " R11 request cycles"}, req_cnt - base, att * LAT);
    bus_read(8'h00, rd);
    check({tag, " R2 command readback"}, rd, cmd);
    if (op == 5'd1) begin
      exp_rd = '0;
      for (int k = 0; k < ok; k++) exp_rd[8*k +: 8] = exp_mem[(int'(addr) + k) & 255];
      bus_read(8'h18, rd);
      check({tag, " R4 read word0"}, rd, exp_rd[31:0]);
      bus_read(8'h1C, rd);
      check({tag, " R4 read word1"}, rd, exp_rd[63:32]);
    end
    if (op == 5'd0) begin
      for (int k = 0; k < ok; k++) exp_mem[(int'(addr) + k) & 255] = wb[8*k +: 8];
      for (int k = 0; k < 8; k++)
        check({tag, " R3 peripheral byte"}, {24'b0, pmem[(int'(addr) + k) & 255]},
              {24'b0, exp_mem[(int'(addr) + k) & 255]});
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    process::self().srandom(32'd1234);
    for (int i = 0; i < 256; i++) begin
      pmem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(8'h08, rd); check("R1 status", rd, 32'h0);
    bus_read(8'h10, rd); check("R1 wdata0", rd, 32'h0);
    bus_read(8'h14, rd); check("R1 wdata1", rd, 32'h0);
    bus_read(8'h18, rd); check("R1 rdata0", rd, 32'h0);
    bus_read(8'h1C, rd); check("R1 rdata1", rd, 32'h0);
    bus_read(8'h04, rd); check("R1 config", rd, 32'h0);
    check("R1 no request", {31'b0, per_req}, 32'h0);

    // directed corners
    run(5'd0, 8'h10, 3'd7, 32'h44332211, 32'h88776655, 0, 0); // R3 full 8 bytes
    run(5'd1, 8'h10, 3'd7, 32'h0, 32'h0, 0, 0);               // R4 full 8 bytes
    run(5'd1, 8'h12, 3'd0, 32'h0, 32'h0, 0, 0);               // R4 single byte, rest zero
    run(5'd1, 8'hF6, 3'd3, 32'h0, 32'h0, 0, 0);               // R7 refusal at third byte
    run(5'd0, 8'hFA, 3'd1, 32'hA5A5A5A5, 32'h0, 0, 0);        // R7 refusal at first byte
    run(5'd0, 8'hF5, 3'd5, 32'hDEADBEEF, 32'hCAFEF00D, 0, 0); // R7 partial write
    run(5'd5, 8'h30, 3'd2, 32'h0, 32'h0, 0, 0);               // R8
    run(5'd2, 8'h30, 3'd2, 32'h0, 32'h0, 0, 0);               // R8 short extended write
    run(5'd16, 8'h30, 3'd0, 32'h0, 32'h0, 0, 0);              // R8
    run(5'd0, 8'h40, 3'd3, 32'h12345678, 32'h0, 1, 0);        // R9 denied
    run(5'd1, 8'h40, 3'd3, 32'h0, 32'h0, 1, 0);               // R9 reads still work
    run(5'd1, 8'h20, 3'd3, 32'h0, 32'h0, 0, 1);               // R10 dropped
    run(5'd0, 8'h50, 3'd0, 32'h000000EE, 32'h0, 0, 1);        // R10 dropped on write

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [4:0] op;
      logic [7:0] a;
      int sel;
      sel = int'($urandom % 8);
      if (sel < 3) op = 5'd0;
      else if (sel < 6) op = 5'd1;
      else op = 5'(2 + $urandom % 15);
      a = ($urandom % 4 == 0) ? 8'(8'hF0 + $urandom % 16) : 8'($urandom);
      run(op, a, 3'($urandom), $urandom, $urandom,
          ($urandom % 6 == 0), ($urandom % 8 == 0));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule